// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a small fully associative cache of page translations. A requester presents a virtual address, and one cycle later the block answers with hit or miss, the physical address (translated frame number joined to the untranslated page offset) and the permission bits of the page. Every entry carries the address-space identifier it was loaded under and a global flag. An entry takes part in a lookup only when its identifier equals the current identifier input or its global flag is set. Two processes can therefore keep mappings of the same virtual page side by side, and shared pages stay visible to all of them.

On a miss the requester obtains the mapping elsewhere (a page walker or a software handler) and writes it in through the refill port. The retried lookup then hits. A refill first looks for an entry with the same page and identifier and overwrites it. If there is none, it takes a free slot. If the buffer is full, it evicts slots in first-in, first-out order. Three maintenance commands keep the contents coherent: drop everything, drop all non-global entries on a context switch, or drop the entry that translates one given page.

Top module: `xlat_cache`

## Requirements
- R1: After reset every entry is invalid, the eviction pointer is at slot 0, and `rsp_valid` is low.
- R2: A lookup (`lk_req` high, `fill_en` low) gives `rsp_valid` high on the next cycle. It hits when a valid entry has a page number equal to `lk_vaddr[31:12]` and either its global flag is set or all 12 identifier bits equal `cur_asid`. If several entries match, the lowest-numbered slot supplies the result.
- R3: On a hit `rsp_paddr` is {stored frame, `lk_vaddr[11:0]`} and `rsp_perm` is the stored permission field. On a miss `rsp_hit`, `rsp_paddr` and `rsp_perm` are all zero.
- R4: A lookup requested in the same cycle as `fill_en` is not served: `rsp_valid` stays low on the next cycle and the requester must retry.
- R5: A refill whose page number and identifier both equal those of a valid entry overwrites that entry (frame, permissions, global flag) instead of allocating a second one.
- R6: Any other refill goes into the lowest-numbered invalid slot. When no slot is free, it replaces the slot named by the eviction pointer, and the pointer then advances by one modulo the entry count. Starting from an empty buffer, the oldest fill is therefore evicted first.
- R7: `flush_all` invalidates every entry.
- R8: `flush_nonglobal` invalidates every entry whose global flag is clear and leaves global entries usable.
- R9: `inval_en` invalidates only the entries that a lookup of page `inval_vpn` under the current identifier would hit. All other entries, including the same page under a different non-global identifier, remain.
- R10: The maintenance commands rank `flush_all`, then `flush_nonglobal`, then `inval_en`; only the highest-ranked one takes effect. A refill issued in a cycle with any maintenance command is dropped. A lookup in such a cycle is answered from the contents as they were before the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_asid | input | 12 | Identifier of the running address space |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | A lookup result is present this cycle |
| rsp_hit | output | 1 | The lookup found a translation |
| rsp_paddr | output | 32 | Physical address, zero on miss |
| rsp_perm | output | 4 | Permission bits, zero on miss |
| fill_en | input | 1 | Write a translation |
| fill_vpn | input | 20 | Virtual page number of the refill |
| fill_asid | input | 12 | Identifier of the refill |
| fill_global | input | 1 | Refilled page is shared by all identifiers |
| fill_pfn | input | 20 | Physical frame number of the refill |
| fill_perm | input | 4 | Permission bits of the refill |
| flush_all | input | 1 | Invalidate all entries |
| flush_nonglobal | input | 1 | Invalidate all non-global entries |
| inval_en | input | 1 | Invalidate the entry translating `inval_vpn` |
| inval_vpn | input | 20 | Virtual page number to invalidate |

## Verification
The bench builds the block with four entries and keeps the default address, frame and identifier widths. With four entries a few refills fill the buffer, so eviction order, wraparound of the eviction pointer and the choice between a free slot and a victim all come up in both the directed and the random phase. The full 12-bit identifier is kept so that identifiers differing only in their top bit stay distinct. The random phase uses a page space of eight pages and two identifiers. This makes duplicate refills, overlapping global and private mappings of one page, and lookups that coincide with maintenance commands frequent.

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int ENTRIES = 16,
  parameter int VA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int PFN_W   = 20,
  parameter int ASID_W  = 12,
  parameter int PERM_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ASID_W-1:0]       cur_asid,
  input  logic                    lk_req,
  input  logic [VA_W-1:0]         lk_vaddr,
  output logic                    rsp_valid,
  output logic                    rsp_hit,
  output logic [PFN_W+OFF_W-1:0]  rsp_paddr,
  output logic [PERM_W-1:0]       rsp_perm,
  input  logic                    fill_en,
  input  logic [VA_W-OFF_W-1:0]   fill_vpn,
  input  logic [ASID_W-1:0]       fill_asid,
  input  logic                    fill_global,
  input  logic [PFN_W-1:0]        fill_pfn,
  input  logic [PERM_W-1:0]       fill_perm,
  input  logic                    flush_all,
  input  logic                    flush_nonglobal,
  input  logic                    inval_en,
  input  logic [VA_W-OFF_W-1:0]   inval_vpn
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PA_W  = PFN_W + OFF_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld, glb;
  logic [VPN_W-1:0]   tag_q  [ENTRIES];
  logic [ASID_W-1:0]  asid_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q  [ENTRIES];
  logic [PERM_W-1:0]  perm_q [ENTRIES];
  logic [IDX_W-1:0]   rep_ptr;

  logic [ENTRIES-1:0] lk_match, inv_match, dup_match;
  logic [IDX_W-1:0]   hit_idx, dup_idx, free_idx, fill_idx;
  logic               hit_any, dup_any, free_any, evict, maint, do_fill, accept;

  wire [VPN_W-1:0] lk_vpn = lk_vaddr[VA_W-1:OFF_W];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign lk_match[i]  = vld[i] && tag_q[i] == lk_vpn    && (glb[i] || asid_q[i] == cur_asid);
    assign inv_match[i] = vld[i] && tag_q[i] == inval_vpn && (glb[i] || asid_q[i] == cur_asid);
    assign dup_match[i] = vld[i] && tag_q[i] == fill_vpn  && asid_q[i] == fill_asid;
  end

  always_comb begin
    hit_idx  = '0;
    dup_idx  = '0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lk_match[i])  hit_idx  = IDX_W'(i);
      if (dup_match[i]) dup_idx  = IDX_W'(i);
      if (!vld[i])      free_idx = IDX_W'(i);
    end
  end

  assign hit_any  = |lk_match;
  assign dup_any  = |dup_match;
  assign free_any = ~&vld;
  assign evict    = !dup_any && !free_any;
  assign fill_idx = dup_any ? dup_idx : (free_any ? free_idx : rep_ptr);
  assign maint    = flush_all || flush_nonglobal || inval_en;
  assign do_fill  = fill_en && !maint;
  assign accept   = lk_req && !fill_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld     <= '0;
      glb     <= '0;
      rep_ptr <= '0;
    end else if (flush_all) begin
      vld <= '0;
    end else if (flush_nonglobal) begin
      vld <= vld & glb;
    end else if (inval_en) begin
      vld <= vld & ~inv_match;
    end else if (fill_en) begin
      vld[fill_idx] <= 1'b1;
      glb[fill_idx] <= fill_global;
      if (evict)
        rep_ptr <= (rep_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rep_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_fill) begin
      tag_q[fill_idx]  <= fill_vpn;
      asid_q[fill_idx] <= fill_asid;
      pfn_q[fill_idx]  <= fill_pfn;
      perm_q[fill_idx] <= fill_perm;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_paddr <= '0;
      rsp_perm  <= '0;
    end else begin
      rsp_valid <= accept;
      rsp_hit   <= accept && hit_any;
      rsp_paddr <= (accept && hit_any) ? PA_W'({pfn_q[hit_idx], lk_vaddr[OFF_W-1:0]}) : '0;
      rsp_perm  <= (accept && hit_any) ? perm_q[hit_idx] : '0;
    end
  end

  a_r2_lookup_answered: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);

  a_r3_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_paddr[OFF_W-1:0] == ($past(lk_vaddr[OFF_W-1:0]) & {OFF_W{rsp_hit}}));

  a_r3_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_paddr == '0 && rsp_perm == '0));

  a_r4_fill_blocks_lookup: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> !rsp_valid);

  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> vld == '0);

  a_r8_globals_survive: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_nonglobal && !flush_all) |=> ((vld & ~glb) == '0 && (vld & glb) == $past(vld & glb)));

  a_r10_fill_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && maint) |=> $stable(rep_ptr));
endmodule

// File: tb/test_xlat_cache.sv
module test_xlat_cache;
  localparam int N = 4, VA_W = 32, OFF_W = 12, PFN_W = 20, ASID_W = 12, PERM_W = 4;
  localparam int VPN_W = VA_W - OFF_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [ASID_W-1:0] cur_asid = '0;
  logic lk_req = 0;
  logic [VA_W-1:0] lk_vaddr = '0;
  logic rsp_valid, rsp_hit;
  logic [PFN_W+OFF_W-1:0] rsp_paddr;
  logic [PERM_W-1:0] rsp_perm;
  logic fill_en = 0, fill_global = 0;
  logic [VPN_W-1:0] fill_vpn = '0, inval_vpn = '0;
  logic [ASID_W-1:0] fill_asid = '0;
  logic [PFN_W-1:0] fill_pfn = '0;
  logic [PERM_W-1:0] fill_perm = '0;
  logic flush_all = 0, flush_nonglobal = 0, inval_en = 0;

  xlat_cache #(.ENTRIES(N), .VA_W(VA_W), .OFF_W(OFF_W), .PFN_W(PFN_W),
               .ASID_W(ASID_W), .PERM_W(PERM_W)) i_xlat_cache (
    .clk(clk), .rst_n(rst_n), .cur_asid(cur_asid), .lk_req(lk_req), .lk_vaddr(lk_vaddr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr), .rsp_perm(rsp_perm),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_asid(fill_asid), .fill_global(fill_global),
    .fill_pfn(fill_pfn), .fill_perm(fill_perm), .flush_all(flush_all),
    .flush_nonglobal(flush_nonglobal), .inval_en(inval_en), .inval_vpn(inval_vpn));

  always #4 clk = ~clk;

  bit m_v [N];
  bit m_g [N];
  logic [VPN_W-1:0] m_vpn [N];
  logic [ASID_W-1:0] m_asid [N];
  logic [PFN_W-1:0] m_pfn [N];
  logic [PERM_W-1:0] m_perm [N];
  int m_ptr;
  int total = 0, bad = 0;
  bit done = 0;

  function automatic bit visible(int k, logic [VPN_W-1:0] v);
    return m_v[k] && m_vpn[k] == v && (m_g[k] || m_asid[k] == cur_asid);
  endfunction

  task automatic model_reset();
    for (int k = 0; k < N; k++) begin m_v[k] = 0; m_g[k] = 0; end
    m_ptr = 0;
  endtask

  task automatic step(input string req);
    bit e_valid, e_hit;
    logic [31:0] e_pa;
    logic [PERM_W-1:0] e_perm;
    int slot;
    e_valid = lk_req && !fill_en;
    e_hit = 0; e_pa = '0; e_perm = '0;
    if (e_valid)
      for (int k = N - 1; k >= 0; k--)
        if (visible(k, lk_vaddr[31:12])) begin
          e_hit = 1; e_pa = {m_pfn[k], lk_vaddr[11:0]}; e_perm = m_perm[k];
        end
    if (flush_all) begin
      for (int k = 0; k < N; k++) m_v[k] = 0;
    end else if (flush_nonglobal) begin
      for (int k = 0; k < N; k++) if (!m_g[k]) m_v[k] = 0;
    end else if (inval_en) begin
      bit kill [N];
      for (int k = 0; k < N; k++) kill[k] = visible(k, inval_vpn);
      for (int k = 0; k < N; k++) if (kill[k]) m_v[k] = 0;
    end else if (fill_en) begin
      slot = -1;
      for (int k = N - 1; k >= 0; k--)
        if (m_v[k] && m_vpn[k] == fill_vpn && m_asid[k] == fill_asid) slot = k;
      if (slot < 0)
        for (int k = N - 1; k >= 0; k--) if (!m_v[k]) slot = k;
      if (slot < 0) begin
        slot = m_ptr;
        m_ptr = (m_ptr + 1) % N;
      end
      m_v[slot] = 1; m_g[slot] = fill_global; m_vpn[slot] = fill_vpn;
      m_asid[slot] = fill_asid; m_pfn[slot] = fill_pfn; m_perm[slot] = fill_perm;
    end
    @(posedge clk);
    @(negedge clk);
    total++;
    if (rsp_valid !== e_valid || rsp_hit !== e_hit || rsp_paddr !== e_pa || rsp_perm !== e_perm) begin
      bad++;
      $display("FAIL %s: valid/hit/paddr/perm actual %b/%b/%h/%h expected %b/%b/%h/%h",
               req, rsp_valid, rsp_hit, rsp_paddr, rsp_perm, e_valid, e_hit, e_pa, e_perm);
    end
    lk_req = 0; fill_en = 0; flush_all = 0; flush_nonglobal = 0; inval_en = 0;
  endtask

  task automatic look(input logic [31:0] va, input string req);
    lk_req = 1; lk_vaddr = va; step(req);
  endtask

  task automatic put(input logic [19:0] v, input logic [11:0] a, input bit g,
                     input logic [19:0] p, input logic [3:0] pm, input string req);
    fill_en = 1; fill_vpn = v; fill_asid = a; fill_global = g; fill_pfn = p; fill_perm = pm;
    step(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual still running, expected finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_asid = 12'h005;
    step("R1");
    look(32'h0000_1234, "R1");

    put(20'h00010, 12'h005, 0, 20'hABCDE, 4'h5, "R6");
    look(32'h0001_07FF, "R2");
    look(32'h0001_0000, "R3");
    put(20'h00020, 12'h805, 0, 20'h22222, 4'h3, "R6");
    look(32'h0002_0ABC, "R2");
    cur_asid = 12'h805;
    look(32'h0002_0ABC, "R2");
    look(32'h0001_0001, "R3");
    cur_asid = 12'h005;
    put(20'h00030, 12'h123, 1, 20'h33333, 4'h9, "R6");
    look(32'h0003_0FFF, "R2");

    lk_req = 1; lk_vaddr = 32'h0004_0010;
    put(20'h00040, 12'h005, 0, 20'h44444, 4'hC, "R4");
    look(32'h0004_0010, "R4");

    put(20'h00010, 12'h005, 0, 20'h11111, 4'hA, "R5");
    look(32'h0001_0555, "R5");
    put(20'h00050, 12'h005, 0, 20'h55555, 4'h1, "R6");
    look(32'h0001_0555, "R6");
    cur_asid = 12'h805;
    look(32'h0002_0001, "R6");
    cur_asid = 12'h005;
    put(20'h00060, 12'h005, 0, 20'h66666, 4'h2, "R6");
    cur_asid = 12'h805;
    look(32'h0002_0001, "R6");
    cur_asid = 12'h005;

    inval_en = 1; inval_vpn = 20'h00040; step("R9");
    look(32'h0004_0010, "R9");
    look(32'h0005_0010, "R9");
    cur_asid = 12'h777;
    inval_en = 1; inval_vpn = 20'h00050; step("R9");
    cur_asid = 12'h005;
    look(32'h0005_0020, "R9");

    flush_nonglobal = 1; step("R8");
    look(32'h0003_0100, "R8");
    look(32'h0005_0100, "R8");

    lk_req = 1; lk_vaddr = 32'h0003_0200; flush_all = 1; step("R10");
    flush_all = 1; fill_en = 1; fill_vpn = 20'h00070; fill_asid = 12'h005;
    fill_global = 0; fill_pfn = 20'h77777; fill_perm = 4'h7; step("R10");
    look(32'h0007_0000, "R10");
    look(32'h0003_0200, "R7");

    for (int c = 0; c < 4000; c++) begin
      cur_asid = ($urandom % 2 == 0) ? 12'h005 : 12'h805;
      lk_req = ($urandom % 10) < 6;
      lk_vaddr = {17'h0, 3'($urandom), 12'($urandom)};
      fill_en = ($urandom % 10) < 3;
      fill_vpn = {17'h0, 3'($urandom)};
      fill_asid = ($urandom % 2 == 0) ? 12'h005 : 12'h805;
      fill_global = ($urandom % 5) == 0;
      fill_pfn = 20'($urandom);
      fill_perm = 4'($urandom);
      flush_all = ($urandom % 100) == 0;
      flush_nonglobal = ($urandom % 50) == 0;
      inval_en = ($urandom % 25) == 0;
      inval_vpn = {17'h0, 3'($urandom)};
      step("R2/R5/R6/R10");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule